// File: doc/BRIEF.md
# Serial DAC Link Retiming Aligner

This block cleans up the three wires of a serial audio DAC link: the bit clock, the serial data and the latch strobe that tells the converter to take a finished word. Each wire is sampled into its own shift register running on a local master clock. Each output is taken from a chosen stage, so every edge that leaves the block sits on a master-clock edge.

The latch strobe stage is set by a 3-bit delay setting. Bit clock and data share a second tap, equal to the latch tap minus a 0-or-1 trim with a floor of zero. The words and the strobe therefore move together, and a late strobe cannot fall inside the next word. A new setting is taken only when the latch input and every stage of the latch register have been low. A build parameter moves all retiming registers to the falling master-clock edge. This shifts every output half a master cycle earlier, which leaves room for propagation delay.

Top module: `rclk_aligner`

## Requirements
- R1: An active-low asynchronous reset clears every stage of all three shift registers and sets both taps to 0, so all three outputs read 0 while reset is held.
- R2: With latch tap `t` (0 to STAGES-1), `latchOut` equals `latchIn` as sampled `t+1` core-clock edges earlier. Tap 0 gives a single register of latency.
- R3: `dataOut` equals `dataIn` delayed by `p+1` core-clock edges. The path tap is `p = t - offsetSel` when `t >= offsetSel`, and 0 otherwise. `offsetSel` = 1 removes one stage relative to the latch.
- R4: `bitClkOut` uses the same path tap as `dataOut`, so bit clock and data always leave with identical latency.
- R5: `delaySel` and `offsetSel` are loaded on a core-clock edge only if `latchIn` is 0 at that edge and was 0 at each of the previous STAGES edges. At any other edge both inputs have no effect on the outputs. On the cycle after a load, `latchOut` is 0.
- R6: With `FALL_EDGE` = 1, all registers sample on the falling master-clock edge. For the same input sequence, each output value appears half a master cycle before it appears in the rising-edge build.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rstN | input | 1 | Asynchronous active-low reset |
| bitClkIn | input | 1 | Raw bit clock |
| dataIn | input | 1 | Raw serial data |
| latchIn | input | 1 | Raw latch strobe (high ends a word) |
| delaySel | input | TAP_W (3) | Requested latch tap, 0 to STAGES-1 |
| offsetSel | input | 1 | 1: path tap one stage below latch tap |
| bitClkOut | output | 1 | Retimed bit clock |
| dataOut | output | 1 | Retimed data |
| latchOut | output | 1 | Retimed latch strobe |

## Verification
The bench builds two copies with STAGES = 8 from the same stimulus. One samples on the rising edge (FALL_EDGE = 0) and one on the falling edge (FALL_EDGE = 1). Because of this, the half-cycle lead is checked directly against the same expected stream, and all eight taps are reachable with both trim values, including the floor at tap 0 with trim 1. Framed words with latch pulses of several lengths, and settings that change mid-word, exercise the quiet-window rule for loading.

// File: rtl/rclk_pkg.sv
package rclk_pkg;

  // Strobes issued by the control unit to the datapath each core cycle.
  typedef struct packed {
    logic tapLoad;   // taps are being replaced at this edge
    logic armed;     // at least one edge has passed since reset
  } rclk_strobe_t;

endpackage

// File: rtl/rclk_delay_line.sv
module rclk_delay_line #(
  parameter int STAGES = 8,
  localparam int TAP_W = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             din,
  input  logic [TAP_W-1:0] tap,
  output logic             dout
);

  logic [STAGES-1:0] stageQ;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stageQ <= '0;
    else       stageQ <= {stageQ[STAGES-2:0], din};
  end

  // Stage 0 holds the newest sample; a tap beyond the last stage clamps.
  always_comb begin
    if (int'(tap) < STAGES) dout = stageQ[tap];
    else                    dout = stageQ[STAGES-1];
  end

endmodule

// File: rtl/rclk_ctrl.sv
module rclk_ctrl
  import rclk_pkg::*;
#(
  parameter int STAGES = 8,
  localparam int TAP_W = $clog2(STAGES),
  localparam int CNT_W = $clog2(STAGES + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             latchIn,
  input  logic [TAP_W-1:0] delaySel,
  input  logic             offsetSel,
  output logic [TAP_W-1:0] latchTap,
  output logic [TAP_W-1:0] pathTap,
  output rclk_strobe_t     strobes
);

  localparam logic [CNT_W-1:0] RUN_FULL = CNT_W'(STAGES);

  logic [CNT_W-1:0] lowRun;     // edges with latch low, saturating
  logic             armedQ;
  logic             loadNow;
  logic [TAP_W-1:0] trimmedTap;

  // Loading is allowed only when the whole latch register holds zeros and
  // the incoming sample is zero too, so swapping taps creates no edge.
  assign loadNow = !latchIn && (lowRun == RUN_FULL);

  always_comb begin
    if (delaySel >= TAP_W'(offsetSel)) trimmedTap = delaySel - TAP_W'(offsetSel);
    else                               trimmedTap = '0;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      lowRun   <= RUN_FULL;
      armedQ   <= 1'b0;
      latchTap <= '0;
      pathTap  <= '0;
    end else begin
      armedQ <= 1'b1;
      if (latchIn)                lowRun <= '0;
      else if (lowRun != RUN_FULL) lowRun <= lowRun + 1'b1;
      if (loadNow) begin
        latchTap <= delaySel;
        pathTap  <= trimmedTap;
      end
    end
  end

  assign strobes.tapLoad = loadNow;
  assign strobes.armed   = armedQ;

  // R5: taps stay put at any edge without a load strobe.
  p_tap_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !loadNow |=> ($stable(latchTap) && $stable(pathTap)));

  // R3: the path tap never exceeds the latch tap and trails it by at most one.
  p_path_trim_r3: assert property (@(posedge clk) disable iff (!rstN)
    (pathTap <= latchTap) && ((latchTap - pathTap) <= TAP_W'(1)));

endmodule

// File: rtl/rclk_datapath.sv
module rclk_datapath
  import rclk_pkg::*;
#(
  parameter int STAGES = 8,
  localparam int TAP_W = $clog2(STAGES),
  localparam int LANES = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  rclk_strobe_t     strobes,
  input  logic [TAP_W-1:0] latchTap,
  input  logic [TAP_W-1:0] pathTap,
  input  logic             latchIn,
  input  logic             bitClkIn,
  input  logic             dataIn,
  output logic             latchOut,
  output logic             bitClkOut,
  output logic             dataOut
);

  // Lane 0 is the latch strobe; lanes 1 and 2 share the path tap.
  logic [LANES-1:0] laneIn;
  logic [LANES-1:0] laneOut;

  assign laneIn = {dataIn, bitClkIn, latchIn};

  for (genvar lane = 0; lane < LANES; lane++) begin : g_lane
    logic [TAP_W-1:0] laneTap;
    if (lane == 0) begin : g_latch_sel
      assign laneTap = latchTap;
    end else begin : g_path_sel
      assign laneTap = pathTap;
    end
    rclk_delay_line #(.STAGES(STAGES)) line_i (
      .clk  (clk),
      .rstN (rstN),
      .din  (laneIn[lane]),
      .tap  (laneTap),
      .dout (laneOut[lane])
    );
  end

  assign latchOut  = laneOut[0];
  assign bitClkOut = laneOut[1];
  assign dataOut   = laneOut[2];

  // R5: a tap swap happens only over an empty latch register.
  p_load_flush_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tapLoad |=> !latchOut);

  // R2: at tap 0 the strobe lags its input by exactly one edge.
  p_tap0_latency_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.armed && latchTap == '0) |-> (latchOut == $past(latchIn)));

  // R4: at path tap 0 bit clock and data both lag by exactly one edge.
  p_path0_matched_r4: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.armed && pathTap == '0) |->
      (dataOut == $past(dataIn) && bitClkOut == $past(bitClkIn)));

endmodule

// File: rtl/rclk_aligner.sv
module rclk_aligner
  import rclk_pkg::*;
#(
  parameter int STAGES    = 8,
  parameter bit FALL_EDGE = 1'b0,
  localparam int TAP_W    = $clog2(STAGES)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             bitClkIn,
  input  logic             dataIn,
  input  logic             latchIn,
  input  logic [TAP_W-1:0] delaySel,
  input  logic             offsetSel,
  output logic             bitClkOut,
  output logic             dataOut,
  output logic             latchOut
);

  logic             coreClk;
  logic [TAP_W-1:0] latchTap;
  logic [TAP_W-1:0] pathTap;
  rclk_strobe_t     strobes;

  // The edge choice is fixed at build time.
  if (FALL_EDGE) begin : g_fall
    assign coreClk = ~clk;
  end else begin : g_rise
    assign coreClk = clk;
  end

  rclk_ctrl #(.STAGES(STAGES)) ctrl_i (
    .clk       (coreClk),
    .rstN      (rstN),
    .latchIn   (latchIn),
    .delaySel  (delaySel),
    .offsetSel (offsetSel),
    .latchTap  (latchTap),
    .pathTap   (pathTap),
    .strobes   (strobes)
  );

  rclk_datapath #(.STAGES(STAGES)) path_i (
    .clk       (coreClk),
    .rstN      (rstN),
    .strobes   (strobes),
    .latchTap  (latchTap),
    .pathTap   (pathTap),
    .latchIn   (latchIn),
    .bitClkIn  (bitClkIn),
    .dataIn    (dataIn),
    .latchOut  (latchOut),
    .bitClkOut (bitClkOut),
    .dataOut   (dataOut)
  );

endmodule

// File: tb/rclk_aligner_tb_top.sv
module rclk_aligner_tb_top;

  localparam int STAGES = 8;
  localparam int TAP_W  = $clog2(STAGES);

  logic clk = 1'b0;
  always #10 clk = ~clk;   // 50 MHz

  logic             rstN;
  logic             bitClkIn, dataIn, latchIn, offsetSel;
  logic [TAP_W-1:0] delaySel;
  logic             bcR, dR, lR;   // rising-edge build
  logic             bcF, dF, lF;   // falling-edge build

  rclk_aligner #(.STAGES(STAGES), .FALL_EDGE(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClkIn), .dataIn(dataIn),
    .latchIn(latchIn), .delaySel(delaySel), .offsetSel(offsetSel),
    .bitClkOut(bcR), .dataOut(dR), .latchOut(lR));

  rclk_aligner #(.STAGES(STAGES), .FALL_EDGE(1'b1)) dutFall_i (
    .clk(clk), .rstN(rstN), .bitClkIn(bitClkIn), .dataIn(dataIn),
    .latchIn(latchIn), .delaySel(delaySel), .offsetSel(offsetSel),
    .bitClkOut(bcF), .dataOut(dF), .latchOut(lF));

  typedef struct {
    logic  l;
    logic  b;
    logic  d;
    string tag;
  } exp_t;

  exp_t expQ[$];
  logic hL[$], hB[$], hD[$];   // index 0 = newest sample
  int   mT, mP;
  int   checks = 0;
  int   fails  = 0;
  bit   done   = 1'b0;

  task automatic check1(string tag, string what, logic got, logic exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s %s actual %b expected %b", tag, what, got, exp);
    end
  endtask

  task automatic modelReset();
    hL.delete(); hB.delete(); hD.delete();
    for (int i = 0; i <= STAGES; i++) begin
      hL.push_back(1'b0); hB.push_back(1'b0); hD.push_back(1'b0);
    end
    mT = 0;
    mP = 0;
  endtask

  // Driver: apply one cycle of stimulus and queue the expected outputs.
  task automatic drive(logic l, logic b, logic d, int sel, logic off, string tag);
    bit quiet;
    @(posedge clk);
    #5;
    latchIn = l; bitClkIn = b; dataIn = d;
    delaySel = TAP_W'(sel); offsetSel = off;
    quiet = 1'b1;
    for (int i = 0; i < STAGES; i++) if (hL[i]) quiet = 1'b0;
    if (!l && quiet) begin   // R5 load rule
      mT = sel;
      mP = (sel >= int'(off)) ? sel - int'(off) : 0;
    end
    hL.push_front(l); void'(hL.pop_back());
    hB.push_front(b); void'(hB.pop_back());
    hD.push_front(d); void'(hD.pop_back());
    expQ.push_back('{hL[mT], hB[mP], hD[mP], tag});
  endtask

  // One 16-cycle word; latch high on the last hiLen cycles.
  task automatic word(int sel, logic off, int hiLen, string tag);
    for (int c = 0; c < 16; c++)
      drive(c >= 16 - hiLen, c[0], 1'($urandom % 2), sel, off, tag);
  endtask

  // Monitor: fall build checked half a cycle early, rise build at the edge after.
  initial begin
    forever begin
      @(negedge clk);
      #5;
      if (expQ.size() > 0) begin
        check1("R6", "fall latchOut", lF, expQ[0].l);
        check1("R6", "fall bitClkOut", bcF, expQ[0].b);
        check1("R6", "fall dataOut", dF, expQ[0].d);
      end
      @(posedge clk);
      #3;
      if (expQ.size() > 0) begin
        exp_t e;
        e = expQ.pop_front();
        check1(e.tag, "latchOut", lR, e.l);
        check1("R4", "bitClkOut", bcR, e.b);
        check1("R3", "dataOut", dR, e.d);
      end
    end
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic resetCheck();
    check1("R1", "rise latchOut", lR, 1'b0);
    check1("R1", "rise bitClkOut", bcR, 1'b0);
    check1("R1", "rise dataOut", dR, 1'b0);
    check1("R1", "fall latchOut", lF, 1'b0);
    check1("R1", "fall bitClkOut", bcF, 1'b0);
    check1("R1", "fall dataOut", dF, 1'b0);
  endtask

  initial begin
    rstN = 1'b0;
    latchIn = 1'b1; bitClkIn = 1'b1; dataIn = 1'b1;
    delaySel = '1; offsetSel = 1'b1;
    modelReset();
    repeat (3) @(posedge clk);
    #5;
    resetCheck();   // R1: inputs high, outputs held low
    latchIn = 1'b0; bitClkIn = 1'b0; dataIn = 1'b0;
    delaySel = '0; offsetSel = 1'b0;
    rstN = 1'b1;

    // R2: every latch tap with no trim
    for (int s = 0; s < STAGES; s++)
      for (int w = 0; w < 3; w++) word(s, 1'b0, 2 + w, "R2");

    // R3: trim of one stage, then the floor at tap 0
    for (int w = 0; w < 3; w++) word(4, 1'b1, 3, "R3");
    for (int w = 0; w < 3; w++) word(7, 1'b1, 1, "R3");
    for (int w = 0; w < 3; w++) word(0, 1'b1, 2, "R3");

    // R5: setting changes every cycle, including over latch-high spans
    for (int w = 0; w < 4; w++)
      for (int c = 0; c < 16; c++)
        drive(c >= 10, c[0], 1'($urandom % 2), (c * 3 + w) % STAGES,
              1'(c % 2), "R5");
    // R5: a long latch-high stretch while the setting keeps moving
    for (int c = 0; c < 12; c++) drive(1'b1, c[0], 1'($urandom % 2), c % STAGES, 1'b0, "R5");
    for (int c = 0; c < 20; c++) drive(1'b0, c[0], 1'($urandom % 2), 5, 1'b0, "R5");

    // R1: mid-run reset clears taps and stages
    repeat (3) @(posedge clk);
    #5;
    rstN = 1'b0;
    latchIn = 1'b1; bitClkIn = 1'b1; dataIn = 1'b1;
    #2;
    resetCheck();
    modelReset();
    @(posedge clk);
    #5;
    latchIn = 1'b0; bitClkIn = 1'b0; dataIn = 1'b0;
    delaySel = TAP_W'(6); offsetSel = 1'b1;
    rstN = 1'b1;

    // R2: mixed words after reset with random taps
    for (int w = 0; w < 10; w++)
      word(int'($urandom % STAGES), 1'($urandom % 2), 1 + w % 4, "R2");

    repeat (3) @(posedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule